// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small processor built around one accumulator. It executes one instruction at a time. Every register transfer of the fetch, the decode and the execute phase takes its own clock cycle. It holds a program counter, an address register, a data register, an instruction register and the accumulator. One synchronous memory array holds both the program and the data. That memory has a single port, so any given cycle carries at most one access.

Each instruction word is 16 bits. The top four bits are the opcode and the lower twelve bits are a direct address. The opcodes are:

| Opcode | Operation |
|---|---|
| 1 | load |
| 2 | add |
| 3 | subtract |
| 4 | store |
| 5 | jump |
| 0xF | halt |

Any other opcode does nothing and falls straight through to the next fetch. A testbench or a surrounding system preloads the memory through a write port, which is honoured only while reset is held. It then releases reset and watches the processor's progress at its outputs.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter is set to `START_ADDR`, the accumulator and the overflow flag are cleared, `halted_o` is low, and the next step after release is the first fetch step.
- R2: The first fetch step copies the program counter into the address register and increments the program counter. One cycle after reset release, `pc_o` equals `START_ADDR + 1`.
- R3: Load (opcode 1) reads memory at its 12-bit operand address and places the word in the accumulator.
- R4: Add (opcode 2) and subtract (opcode 3) read their operand word and replace the accumulator with accumulator plus or minus that word, modulo 2^16.
- R5: `ovf_o` is updated only by add and subtract. It is set when the true signed result lies outside -32768..32767, regardless of any carry out of bit 15.
- R6: Store (opcode 4) produces exactly one memory write. During that write, `wr_addr_o` is the operand address and `wr_data_o` equals the accumulator.
- R7: Jump (opcode 5) replaces the already incremented program counter with its operand, so the word after the jump is never executed.
- R8: Halt (opcode 0xF) raises `halted_o` and holds it until reset. While halted, `pc_o` stays at the halt word's address plus one and no memory write occurs.
- R9: No cycle carries both an instruction read (`ifetch_o`) and a data access (`dread_o` or `wr_en_o`).
- R10: Each instruction takes a fixed number of cycles, counted from its first fetch step: load, add and subtract take 9; store takes 8; jump takes 6; halt raises `halted_o` after 5.
- R11: An opcode outside the defined set changes nothing except the program counter increment, and it takes 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Preload write enable, honoured only while `rst` is high |
| ld_addr | input | MEM_AW | Preload word address |
| ld_data | input | DW | Preload word |
| pc_o | output | DW-4 | Program counter |
| acc_o | output | DW | Accumulator |
| ovf_o | output | 1 | Signed overflow of the latest add or subtract |
| halted_o | output | 1 | Processor is halted |
| ifetch_o | output | 1 | Instruction read cycle on the memory port |
| dread_o | output | 1 | Operand read cycle on the memory port |
| wr_en_o | output | 1 | Store write cycle on the memory port |
| wr_addr_o | output | DW-4 | Store address |
| wr_data_o | output | DW | Store data |

## Verification
The assertions assume that the preload port is used only while reset is high. They also assume that every word the program reads, whether an instruction or an operand, was preloaded beforehand, so no unknown value reaches the opcode decode or the accumulator. The bench meets both assumptions by preloading a whole program and its operands under reset, and by choosing every operand address inside the populated region of the memory. The add and subtract sweep uses a grid of boundary values around zero and both signed extremes, so that carry without overflow and overflow without carry both occur.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPW-1:0] OP_ADD   = 4'h2;
  localparam logic [OPW-1:0] OP_SUB   = 4'h3;
  localparam logic [OPW-1:0] OP_STORE = 4'h4;
  localparam logic [OPW-1:0] OP_JMP   = 4'h5;
  localparam logic [OPW-1:0] OP_HALT  = 4'hF;

  typedef enum logic [3:0] {
    S_FADDR, S_FWAIT, S_FDATA, S_FIR, S_DEC,
    S_XADDR, S_XWAIT, S_XDATA, S_XALU,
    S_SDATA, S_SADDR, S_SWR,
    S_JMP, S_HALT
  } step_t;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // one-cycle read latency: rdata reflects raddr of the previous edge
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          ovf
);
  // wrap-around add or subtract
  function automatic logic [DW-1:0] wrap_op(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                            input logic s);
    return s ? (x - y) : (x + y);
  endfunction

  // signed overflow: operand signs agree, result sign differs (carry ignored)
  function automatic logic sign_ovf(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                    input logic s, input logic [DW-1:0] r);
    logic ys;
    ys = s ? ~y[DW-1] : y[DW-1];
    return (x[DW-1] == ys) && (r[DW-1] != x[DW-1]);
  endfunction

  always_comb begin
    res = wrap_op(a, b, sub);
    ovf = sign_ovf(a, b, sub, res);
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op,
  output step_t          step
);
  step_t nxt;

  always_comb begin
    nxt = step;
    unique case (step)
      S_FADDR: nxt = S_FWAIT;
      S_FWAIT: nxt = S_FDATA;
      S_FDATA: nxt = S_FIR;
      S_FIR:   nxt = S_DEC;
      S_DEC: begin
        case (op)
          OP_LOAD, OP_ADD, OP_SUB: nxt = S_XADDR;
          OP_STORE:                nxt = S_SDATA;
          OP_JMP:                  nxt = S_JMP;
          OP_HALT:                 nxt = S_HALT;
          default:                 nxt = S_FADDR;
        endcase
      end
      S_XADDR: nxt = S_XWAIT;
      S_XWAIT: nxt = S_XDATA;
      S_XDATA: nxt = S_XALU;
      S_XALU:  nxt = S_FADDR;
      S_SDATA: nxt = S_SADDR;
      S_SADDR: nxt = S_SWR;
      S_SWR:   nxt = S_FADDR;
      S_JMP:   nxt = S_FADDR;
      S_HALT:  nxt = S_HALT;
      default: nxt = S_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= S_FADDR;
    else     step <= nxt;
  end

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    step == S_HALT |=> step == S_HALT);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW         = 16,
  parameter int MEM_AW     = 8,
  parameter int START_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [DW-1:0]     ld_data,
  output logic [DW-5:0]     pc_o,
  output logic [DW-1:0]     acc_o,
  output logic              ovf_o,
  output logic              halted_o,
  output logic              ifetch_o,
  output logic              dread_o,
  output logic              wr_en_o,
  output logic [DW-5:0]     wr_addr_o,
  output logic [DW-1:0]     wr_data_o
);
  localparam int AW = DW - OPW;
  localparam logic [AW-1:0] START_PC = AW'(START_ADDR);

  step_t          step;
  logic [AW-1:0]  pc_q, mar_q;
  logic [DW-1:0]  mdr_q, cir_q, acc_q;
  logic           ovf_q;
  logic [DW-1:0]  rdata;
  logic [DW-1:0]  alu_res;
  logic           alu_ovf;

  wire [OPW-1:0] op_w      = cir_q[DW-1:DW-OPW];
  wire [AW-1:0]  operand_w = cir_q[AW-1:0];

  // named internal events
  wire fetch_step = (step == S_FADDR);
  wire jump_step  = (step == S_JMP);
  wire alu_step   = (step == S_XALU);
  wire store_step = (step == S_SWR);

  // memory port: preload only under reset, otherwise the store step
  wire                mem_we    = rst ? ld_en : store_step;
  wire [MEM_AW-1:0]   mem_waddr = rst ? ld_addr : mar_q[MEM_AW-1:0];
  wire [DW-1:0]       mem_wdata = rst ? ld_data : mdr_q;

  acc_cpu_ctrl ctrl_i (
    .clk  (clk),
    .rst  (rst),
    .op   (op_w),
    .step (step)
  );

  acc_cpu_mem #(.DW(DW), .AW(MEM_AW)) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar_q[MEM_AW-1:0]),
    .rdata (rdata)
  );

  acc_cpu_alu #(.DW(DW)) alu_i (
    .a   (acc_q),
    .b   (mdr_q),
    .sub (op_w == OP_SUB),
    .res (alu_res),
    .ovf (alu_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= START_PC;
      mar_q <= '0;
      mdr_q <= '0;
      cir_q <= '0;
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      case (step)
        S_FADDR: begin
          mar_q <= pc_q;
          pc_q  <= pc_q + 1'b1;
        end
        S_FDATA: mdr_q <= rdata;
        S_FIR:   cir_q <= mdr_q;
        S_XADDR: mar_q <= operand_w;
        S_XDATA: mdr_q <= rdata;
        S_XALU: begin
          if (op_w == OP_LOAD) begin
            acc_q <= mdr_q;
          end else begin
            acc_q <= alu_res;
            ovf_q <= alu_ovf;
          end
        end
        S_SDATA: mdr_q <= acc_q;
        S_SADDR: mar_q <= operand_w;
        S_JMP:   pc_q  <= operand_w;
        default: ;
      endcase
    end
  end

  assign pc_o      = pc_q;
  assign acc_o     = acc_q;
  assign ovf_o     = ovf_q;
  assign halted_o  = (step == S_HALT);
  assign ifetch_o  = (step == S_FWAIT);
  assign dread_o   = (step == S_XWAIT);
  assign wr_en_o   = store_step;
  assign wr_addr_o = mar_q;
  assign wr_data_o = mdr_q;

  // R2
  fetch_inc_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_step |=> pc_q == $past(pc_q) + 1'b1);

  // R7
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    jump_step |=> pc_q == $past(operand_w));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o && $stable(pc_q) && !wr_en_o);

  // R9
  one_path_chk: assert property (@(posedge clk) disable iff (rst)
    !(ifetch_o && (dread_o || wr_en_o)));

  // R6
  store_val_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> wr_data_o == acc_q && wr_addr_o == operand_w);

  // R5
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !alu_step |=> $stable(ovf_q));
endmodule

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
  localparam int DW = 16;
  localparam int MEM_AW = 8;
  localparam int START = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [11:0] pc_o, wr_addr_o;
  logic [DW-1:0] acc_o, wr_data_o;
  logic ovf_o, halted_o, ifetch_o, dread_o, wr_en_o;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int ncyc = 0;
  logic [11:0] last_wa;
  logic [15:0] last_wd;

  always #2 clk = ~clk;

  acc_cpu #(.DW(DW), .MEM_AW(MEM_AW), .START_ADDR(START)) dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_o(pc_o), .acc_o(acc_o), .ovf_o(ovf_o), .halted_o(halted_o),
    .ifetch_o(ifetch_o), .dread_o(dread_o), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always @(negedge clk) begin
    if (!rst && wr_en_o) begin
      wr_cnt  <= wr_cnt + 1;
      last_wa <= wr_addr_o;
      last_wd <= wr_data_o;
    end
  end

  always @(posedge clk) begin
    ncyc <= ncyc + 1;
    if (ncyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (act %0d exp <150000)", ncyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input int a);
    return {op, 12'(a)};
  endfunction

  function automatic logic [15:0] val(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h1234;
      6: return 16'hC000;
      default: return 16'h4000;
    endcase
  endfunction

  task automatic put(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = MEM_AW'(a); ld_data = d;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst = 1'b1; ld_en = 1'b0;
    @(negedge clk);
  endtask

  // releases reset, runs to halt, checks R2, R10 and R8
  task automatic run_prog(input int exp_cyc, input int halt_at);
    int cyc;
    int wsave;
    @(negedge clk);
    ld_en = 1'b0; rst = 1'b0; wr_cnt = 0;
    @(posedge clk); cyc = 1;
    @(negedge clk);
    chk(pc_o == 12'(START + 1), "R2 pc after first fetch step", pc_o, START + 1);
    while (!halted_o && cyc < 300) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    chk(cyc == exp_cyc, "R10 cycles to halt", cyc, exp_cyc);
    wsave = wr_cnt;
    repeat (4) @(negedge clk);
    chk(halted_o == 1'b1, "R8 halted held", halted_o, 1);
    chk(pc_o == 12'(halt_at + 1), "R8 pc frozen", pc_o, halt_at + 1);
    chk(wr_cnt == wsave, "R8 no write while halted", wr_cnt, wsave);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pc_o == 12'(START), "R1 pc reset", pc_o, START);
    chk(acc_o == 16'h0, "R1 acc reset", acc_o, 0);
    chk(ovf_o == 1'b0, "R1 ovf reset", ovf_o, 0);
    chk(halted_o == 1'b0, "R1 halted reset", halted_o, 0);

    // sweep: LOAD a; ADD/SUB b; STORE; HALT  (9+9+8+5 = 31 cycles)
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [15:0] a, b, r;
          int sr;
          bit eo;
          a = val(i); b = val(j);
          sr = (s == 1) ? (int'($signed(a)) - int'($signed(b)))
                        : (int'($signed(a)) + int'($signed(b)));
          r  = 16'(sr);
          eo = (sr > 32767) || (sr < -32768);
          put(START + 0, ins(4'h1, 64));
          put(START + 1, ins((s == 1) ? 4'h3 : 4'h2, 65));
          put(START + 2, ins(4'h4, 66));
          put(START + 3, ins(4'hF, 0));
          put(64, a);
          put(65, b);
          run_prog(31, START + 3);
          chk(acc_o == r, "R4 add/sub wrap result", acc_o, r);
          chk(ovf_o == eo, "R5 signed overflow", ovf_o, eo);
          chk(wr_cnt == 1, "R6 single store write", wr_cnt, 1);
          chk(last_wa == 12'd66, "R6 store address", last_wa, 66);
          chk(last_wd == r, "R6 store data", last_wd, r);
          enter_reset();
          chk(halted_o == 1'b0 && acc_o == 16'h0 && ovf_o == 1'b0, "R1 reset after halt",
              {halted_o, ovf_o, acc_o}, 0);
        end
      end
    end

    // R3 / R7: LOAD; JMP over a STORE; STORE; HALT  (9+6+8+5 = 28)
    put(START + 0, ins(4'h1, 64));
    put(START + 1, ins(4'h5, START + 3));
    put(START + 2, ins(4'h4, 80));
    put(START + 3, ins(4'h4, 66));
    put(START + 4, ins(4'hF, 0));
    put(64, 16'hA5C3);
    run_prog(28, START + 4);
    chk(acc_o == 16'hA5C3, "R3 load value", acc_o, 16'hA5C3);
    chk(wr_cnt == 1, "R7 skipped store not executed", wr_cnt, 1);
    chk(last_wa == 12'd66, "R7 jump landed on target", last_wa, 66);
    chk(last_wd == 16'hA5C3, "R6 store after jump", last_wd, 16'hA5C3);
    enter_reset();

    // R11: undefined opcode 6; LOAD; HALT  (5+9+5 = 19)
    put(START + 0, ins(4'h6, 80));
    put(START + 1, ins(4'h1, 65));
    put(START + 2, ins(4'hF, 0));
    put(65, 16'h0F0F);
    run_prog(19, START + 2);
    chk(acc_o == 16'h0F0F, "R11 undefined opcode no effect on acc", acc_o, 16'h0F0F);
    chk(wr_cnt == 0, "R11 undefined opcode no write", wr_cnt, 0);
    chk(ovf_o == 1'b0, "R11 undefined opcode leaves ovf", ovf_o, 0);
    enter_reset();

    // R9: instruction-read and data-access strobes counted over one run
    put(START + 0, ins(4'h1, 64));
    put(START + 1, ins(4'h4, 67));
    put(START + 2, ins(4'hF, 0));
    put(64, 16'h5555);
    @(negedge clk);
    ld_en = 1'b0; rst = 1'b0;
    begin
      int nf = 0, nd = 0, nboth = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (ifetch_o) nf++;
        if (dread_o || wr_en_o) nd++;
        if (ifetch_o && (dread_o || wr_en_o)) nboth++;
      end
      chk(nboth == 0, "R9 shared port overlap", nboth, 0);
      chk(nf == 3, "R9 instruction reads", nf, 3);
      chk(nd == 2, "R9 data accesses", nd, 2);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule